// File: doc/BRIEF.md
# BCD Calendar Time Counter

This block keeps wall-clock time and calendar date in packed BCD registers. An external divider supplies a one-cycle pulse once per second. Each pulse advances seconds, and carries ripple through minutes, hours, date, month and a two-digit year. A three-bit weekday counter advances once per day. Hours run in either a 24-hour or a 12-hour format with an AM/PM flag. February gets a 29th day whenever the year is a multiple of four.

Software or a bus agent sets the time through a parallel load port. There is one write strobe for each field and one data bus for each field. A load always wins over a pulse that arrives in the same cycle. After reset, which stands for a total loss of power, the counter stays frozen until some field has been written. Every load also sends a one-cycle restart pulse back to the divider, so the next second is measured from the write.

Top module: `bcd_calendar_counter`

## Requirements
- R1: Seconds and minutes count 00 to 59 in BCD. Each wraps to 00 and carries into the next field on the step after 59.
- R2: When hour bit 7 is 1 (24-hour format), bits 5:0 hold BCD 00 to 23. The step after 23 gives 00 and advances the date. Bit 7 is never changed by counting.
- R3: When hour bit 7 is 0 (12-hour format), bits 4:0 hold BCD 12, 01 … 11 and bit 5 is the PM flag (1 = PM). The flag toggles on the step from 11 to 12. The date advances only on the step from 11 PM to 12 AM.
- R4: Date wraps to 01 and the month advances after day 31 in months 01, 03, 05, 07, 08, 10 and 12. It does the same after day 30 in months 04, 06, 09 and 11. In February it does so after day 28, or after day 29 in a leap year.
- R5: A year value (BCD 00 to 99) that is divisible by 4, including 00, is a leap year. There is no century exception.
- R6: Month wraps 12 to 01 and advances the year. Year wraps 99 to 00.
- R7: The weekday (3 bits) advances once per date advance, cycling 0 to 6 and back to 0.
- R8: After reset every field reads 00h. This means 12-hour format with the PM flag clear, and weekday 0.
- R9: After reset, second pulses have no effect until at least one field has been loaded. From then on, counting proceeds.
- R10: In a cycle where any strobe of `ld_we` is high, the strobed fields take the load data and the other fields hold. A second pulse in that cycle is discarded. Strobe bits: 0 sec, 1 min, 2 hour, 3 date, 4 month, 5 year, 6 weekday.
- R11: `div_restart` is high for exactly the one cycle that follows each load cycle.
- R12: While `run_en` is low, second pulses are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (total power loss) |
| tick | input | 1 | One-cycle pulse per second |
| run_en | input | 1 | Counting enable |
| ld_we | input | 7 | Per-field load strobes |
| ld_sec | input | 8 | Seconds load value (BCD) |
| ld_min | input | 8 | Minutes load value (BCD) |
| ld_hr | input | 8 | Hour load value incl. format and PM bits |
| ld_date | input | 8 | Date load value (BCD) |
| ld_mon | input | 8 | Month load value (BCD) |
| ld_yr | input | 8 | Year load value (BCD) |
| ld_dow | input | 3 | Weekday load value |
| sec | output | 8 | Seconds |
| min | output | 8 | Minutes |
| hr | output | 8 | Hour with format and PM bits |
| date | output | 8 | Date |
| mon | output | 8 | Month |
| yr | output | 8 | Year |
| dow | output | 3 | Weekday |
| div_restart | output | 1 | Phase restart pulse for the 1 Hz divider |

## Verification
Every field is a single register. A second pulse or a load that is sampled at one rising edge therefore shows up on the outputs right after that edge, including a full carry ripple from seconds to year. `div_restart` follows its load cycle by exactly one edge. The bench drives inputs on falling edges and compares against its arithmetic model on the next falling edge. The restart pulse is checked there and once more one cycle later, when it must be low again. Hours are swept in both formats, and every month-end is swept over twelve years that include leap years and the century wrap.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

    localparam int FIELD_W = 8;
    localparam int DOW_W   = 3;
    localparam int NUM_FLD = 7;

    typedef enum logic {
        FMT_12H = 1'b0,
        FMT_24H = 1'b1
    } hr_fmt_e;

    typedef struct packed {
        logic [FIELD_W-1:0] sec;
        logic [FIELD_W-1:0] min;
        logic [FIELD_W-1:0] hr;
        logic [FIELD_W-1:0] date;
        logic [FIELD_W-1:0] mon;
        logic [FIELD_W-1:0] yr;
        logic [DOW_W-1:0]   dow;
    } cal_t;

    // Advance a packed two-digit BCD value by one.
    function automatic logic [7:0] bcd_step(input logic [7:0] v);
        if (v[3:0] >= 4'd9)
            return {v[7:4] + 4'd1, 4'd0};
        return v + 8'd1;
    endfunction

    function automatic logic [7:0] bcd_to_bin(input logic [7:0] v);
        return (8'({4'b0, v[7:4]}) * 8'd10) + 8'({4'b0, v[3:0]});
    endfunction

    function automatic logic is_leap(input logic [7:0] yr_bcd);
        logic [7:0] b;
        b = bcd_to_bin(yr_bcd);
        return (b[1:0] == 2'b00);
    endfunction

    // Last valid day (BCD) of a month, given the year.
    function automatic logic [7:0] month_last(input logic [7:0] mon_bcd,
                                              input logic [7:0] yr_bcd);
        case (mon_bcd)
            8'h02:                      return is_leap(yr_bcd) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_bcd_field.sv
module rtc_bcd_field
    import rtc_cal_pkg::*;
#(
    parameter int         W     = 8,
    parameter logic [7:0] FIRST = 8'h00
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] ld_val,
    input  logic         inc,
    input  logic [7:0]   last,
    output logic [W-1:0] q,
    output logic         wrap
);

    logic [7:0] q8;
    assign q8   = 8'(q);
    assign wrap = inc && (q8 == last);

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (load)
            q <= ld_val;
        else if (inc)
            q <= wrap ? W'(FIRST) : W'(bcd_step(q8));
    end

    // R1 R4 R6 R7: the step after the last value restarts the field
    a_r1_field_wraps: assert property (@(posedge clk) disable iff (rst)
        (inc && !load && q8 == last) |=> (8'(q) == FIRST));

    // R10: load data wins
    a_r10_load_wins: assert property (@(posedge clk) disable iff (rst)
        load |=> (q == $past(ld_val)));

    a_r10_idle_holds: assert property (@(posedge clk) disable iff (rst)
        (!load && !inc) |=> $stable(q));

endmodule

// File: rtl/rtc_hour_field.sv
module rtc_hour_field
    import rtc_cal_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic [7:0] ld_val,
    input  logic       inc,
    output logic [7:0] q,
    output logic       day_wrap
);

    hr_fmt_e    fmt;
    logic       pm;
    logic [7:0] nxt;

    assign fmt = hr_fmt_e'(q[7]);
    assign pm  = q[5];

    always_comb begin
        nxt      = q;
        day_wrap = 1'b0;
        if (fmt == FMT_24H) begin
            if (q[5:0] == 6'h23) begin
                nxt      = {FMT_24H, 7'h00};
                day_wrap = inc;
            end else begin
                nxt = {FMT_24H, 1'b0, bcd_step({2'b00, q[5:0]})[5:0]};
            end
        end else begin
            if (q[4:0] == 5'h12) begin
                nxt = {FMT_12H, 1'b0, pm, 5'h01};
            end else if (q[4:0] == 5'h11) begin
                nxt      = {FMT_12H, 1'b0, ~pm, 5'h12};
                day_wrap = inc && pm;
            end else begin
                nxt = {FMT_12H, 1'b0, pm, bcd_step({3'b000, q[4:0]})[4:0]};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (load)
            q <= ld_val;
        else if (inc)
            q <= nxt;
    end

    a_r2_format_kept: assert property (@(posedge clk) disable iff (rst)
        (inc && !load) |=> (q[7] == $past(q[7])));

    a_r2_day_wrap_24: assert property (@(posedge clk) disable iff (rst)
        (inc && !load && q[7] && q[5:0] == 6'h23) |=> (q[5:0] == 6'h00));

    a_r3_pm_toggles: assert property (@(posedge clk) disable iff (rst)
        (inc && !load && !q[7] && q[4:0] == 5'h11)
            |=> (q[5] != $past(q[5]) && q[4:0] == 5'h12));

    a_r3_twelve_to_one: assert property (@(posedge clk) disable iff (rst)
        (inc && !load && !q[7] && q[4:0] == 5'h12)
            |=> (q[5] == $past(q[5]) && q[4:0] == 5'h01));

endmodule

// File: rtl/rtc_run_gate.sv
module rtc_run_gate (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic run_en,
    input  logic any_load,
    output logic step,
    output logic armed,
    output logic div_restart
);

    always_ff @(posedge clk) begin
        if (rst) begin
            armed       <= 1'b0;
            div_restart <= 1'b0;
        end else begin
            if (any_load)
                armed <= 1'b1;
            div_restart <= any_load;
        end
    end

    assign step = tick && run_en && armed && !any_load;

    // R9: once armed, stays armed until reset
    a_r9_armed_sticky: assert property (@(posedge clk) disable iff (rst)
        armed |=> armed);

endmodule

// File: rtl/bcd_calendar_counter.sv
module bcd_calendar_counter
    import rtc_cal_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick,
    input  logic                 run_en,
    input  logic [NUM_FLD-1:0]   ld_we,
    input  logic [FIELD_W-1:0]   ld_sec,
    input  logic [FIELD_W-1:0]   ld_min,
    input  logic [FIELD_W-1:0]   ld_hr,
    input  logic [FIELD_W-1:0]   ld_date,
    input  logic [FIELD_W-1:0]   ld_mon,
    input  logic [FIELD_W-1:0]   ld_yr,
    input  logic [DOW_W-1:0]     ld_dow,
    output logic [FIELD_W-1:0]   sec,
    output logic [FIELD_W-1:0]   min,
    output logic [FIELD_W-1:0]   hr,
    output logic [FIELD_W-1:0]   date,
    output logic [FIELD_W-1:0]   mon,
    output logic [FIELD_W-1:0]   yr,
    output logic [DOW_W-1:0]     dow,
    output logic                 div_restart
);

    logic step, armed, any_load;
    logic sec_w, min_w, hr_w, date_w, mon_w, yr_w, dow_w;
    logic [7:0] date_last;

    assign any_load  = |ld_we;
    assign date_last = month_last(mon, yr);

    rtc_run_gate u_gate (
        .clk(clk), .rst(rst), .tick(tick), .run_en(run_en),
        .any_load(any_load), .step(step), .armed(armed),
        .div_restart(div_restart)
    );

    rtc_bcd_field #(.W(FIELD_W), .FIRST(8'h00)) u_sec (
        .clk(clk), .rst(rst), .load(ld_we[0]), .ld_val(ld_sec),
        .inc(step), .last(8'h59), .q(sec), .wrap(sec_w)
    );

    rtc_bcd_field #(.W(FIELD_W), .FIRST(8'h00)) u_min (
        .clk(clk), .rst(rst), .load(ld_we[1]), .ld_val(ld_min),
        .inc(sec_w), .last(8'h59), .q(min), .wrap(min_w)
    );

    rtc_hour_field u_hr (
        .clk(clk), .rst(rst), .load(ld_we[2]), .ld_val(ld_hr),
        .inc(min_w), .q(hr), .day_wrap(hr_w)
    );

    rtc_bcd_field #(.W(FIELD_W), .FIRST(8'h01)) u_date (
        .clk(clk), .rst(rst), .load(ld_we[3]), .ld_val(ld_date),
        .inc(hr_w), .last(date_last), .q(date), .wrap(date_w)
    );

    rtc_bcd_field #(.W(FIELD_W), .FIRST(8'h01)) u_mon (
        .clk(clk), .rst(rst), .load(ld_we[4]), .ld_val(ld_mon),
        .inc(date_w), .last(8'h12), .q(mon), .wrap(mon_w)
    );

    rtc_bcd_field #(.W(FIELD_W), .FIRST(8'h00)) u_yr (
        .clk(clk), .rst(rst), .load(ld_we[5]), .ld_val(ld_yr),
        .inc(mon_w), .last(8'h99), .q(yr), .wrap(yr_w)
    );

    rtc_bcd_field #(.W(DOW_W), .FIRST(8'h00)) u_dow (
        .clk(clk), .rst(rst), .load(ld_we[6]), .ld_val(ld_dow),
        .inc(hr_w), .last(8'h06), .q(dow), .wrap(dow_w)
    );

    // R9: nothing moves before the first load
    a_r9_frozen_until_load: assert property (@(posedge clk) disable iff (rst)
        (!armed && !any_load) |=> ($stable(sec) && $stable(hr) && $stable(date)));

    // R12: run enable low stops counting
    a_r12_run_gate: assert property (@(posedge clk) disable iff (rst)
        (!run_en && !any_load) |=> ($stable(sec) && $stable(min) && $stable(yr)));

    // R11: restart pulse follows a load
    a_r11_restart_pulse: assert property (@(posedge clk) disable iff (rst)
        any_load |=> div_restart);

    a_r11_restart_quiet: assert property (@(posedge clk) disable iff (rst)
        !any_load |=> !div_restart);

    // R6: year wrap lands on the first day of the first month
    a_r6_year_wraps: assert property (@(posedge clk) disable iff (rst)
        (yr_w && !any_load) |=> (yr == 8'h00 && mon == 8'h01 && date == 8'h01));

    // R7: weekday restart coincides with a new day
    a_r7_week_wraps: assert property (@(posedge clk) disable iff (rst)
        (dow_w && !any_load) |=> (dow == 3'd0 && sec == 8'h00));

endmodule

// File: tb/test_bcd_calendar_counter.sv
module test_bcd_calendar_counter;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       run_en = 1'b1;
    logic [6:0] ld_we = '0;
    logic [7:0] ld_sec = '0, ld_min = '0, ld_hr = '0, ld_date = '0, ld_mon = '0, ld_yr = '0;
    logic [2:0] ld_dow = '0;
    logic [7:0] sec, min, hr, date, mon, yr;
    logic [2:0] dow;
    logic       div_restart;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    int ms, mm, mh, md, mmo, my, mw;
    bit f24;

    always #4 clk = ~clk;

    bcd_calendar_counter i_bcd_calendar_counter (
        .clk(clk), .rst(rst), .tick(tick), .run_en(run_en), .ld_we(ld_we),
        .ld_sec(ld_sec), .ld_min(ld_min), .ld_hr(ld_hr), .ld_date(ld_date),
        .ld_mon(ld_mon), .ld_yr(ld_yr), .ld_dow(ld_dow),
        .sec(sec), .min(min), .hr(hr), .date(date), .mon(mon), .yr(yr),
        .dow(dow), .div_restart(div_restart)
    );

    function automatic logic [7:0] bcd(input int x);
        return 8'(((x / 10) << 4) | (x % 10));
    endfunction

    function automatic int mdays(input int mo, input int y);
        if (mo == 2) return (y % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    function automatic logic [7:0] exp_hr();
        int h12;
        if (f24) return 8'h80 | bcd(mh);
        h12 = (mh % 12 == 0) ? 12 : mh % 12;
        return ((mh >= 12) ? 8'h20 : 8'h00) | bcd(h12);
    endfunction

    task automatic model_step();
        ms++;
        if (ms == 60) begin
            ms = 0; mm++;
            if (mm == 60) begin
                mm = 0; mh++;
                if (mh == 24) begin
                    mh = 0; mw = (mw + 1) % 7; md++;
                    if (md > mdays(mmo, my)) begin
                        md = 1; mmo++;
                        if (mmo == 13) begin
                            mmo = 1; my = (my + 1) % 100;
                        end
                    end
                end
            end
        end
    endtask

    task automatic check(input string req, input logic [50:0] got, input logic [50:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic check_time(input string req);
        check(req, {sec, min, hr, date, mon, yr, dow},
              {bcd(ms), bcd(mm), exp_hr(), bcd(md), bcd(mmo), bcd(my), 3'(mw)});
    endtask

    // Load every field from the model in one cycle; returns one cycle later.
    task automatic load_time(input bit fmt, input int h, input int m, input int s,
                             input int d, input int mo, input int y, input int w);
        f24 = fmt; mh = h; mm = m; ms = s; md = d; mmo = mo; my = y; mw = w;
        ld_sec = bcd(s); ld_min = bcd(m); ld_hr = exp_hr(); ld_date = bcd(d);
        ld_mon = bcd(mo); ld_yr = bcd(y); ld_dow = 3'(w);
        ld_we = 7'h7f;
        @(negedge clk);
        ld_we = '0;
    endtask

    task automatic run_ticks(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1;
            @(negedge clk);
            model_step();
            check_time(req);
        end
        tick = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R8 reset state
        check("R8", {sec, min, hr, date, mon, yr, dow, div_restart},
              {48'h0, 3'd0, 1'b0});

        // R9: pulses before any load do nothing
        tick = 1'b1;
        repeat (5) @(negedge clk);
        tick = 1'b0;
        check("R9", {sec, min, hr, date, mon, yr, dow}, 51'h0);

        // R11: restart pulse one cycle after a load, then low
        load_time(1'b1, 23, 59, 50, 31, 12, 99, 6);
        check("R11", {50'h0, div_restart}, {50'h0, 1'b1});
        check_time("R10");
        @(negedge clk);
        check("R11", {50'h0, div_restart}, 51'h0);

        // R1 R2 R4 R6 R7: new year rollover in 24-hour format
        run_ticks(20, "R6");

        // R3: 11 AM -> 12 PM, then 11 PM -> 12 AM next day
        load_time(1'b0, 11, 59, 55, 14, 3, 21, 2);
        run_ticks(10, "R3");
        load_time(1'b0, 23, 59, 55, 30, 4, 21, 6);
        run_ticks(10, "R3");

        // R2 R3: every hour boundary in both formats
        for (int f = 0; f < 2; f++) begin
            for (int h = 0; h < 24; h++) begin
                load_time(f[0], h, 59, 58, 10, 7, 33, h % 7);
                run_ticks(3, f ? "R2" : "R3");
            end
        end

        // R4 R5 R6: every month end over leap, non-leap and wrap years
        for (int yi = 0; yi < 12; yi++) begin
            for (int mo = 1; mo <= 12; mo++) begin
                for (int d = 28; d <= 31; d++) begin
                    if (d <= mdays(mo, (yi < 8) ? yi : 88 + yi)) begin
                        load_time(1'b1, 23, 59, 59, d, mo, (yi < 8) ? yi : 88 + yi, d % 7);
                        run_ticks(1, "R4");
                    end
                end
            end
        end

        // R1: a long continuous run across many minutes
        load_time(1'b0, 0, 0, 0, 28, 2, 24, 3);
        run_ticks(4000, "R1");

        // R12: run enable low blocks pulses
        run_en = 1'b0;
        tick = 1'b1;
        repeat (5) @(negedge clk);
        tick = 1'b0;
        run_en = 1'b1;
        check_time("R12");

        // R10: full load together with a pulse
        f24 = 1'b1; mh = 5; mm = 6; ms = 7; md = 8; mmo = 9; my = 10; mw = 4;
        ld_sec = bcd(ms); ld_min = bcd(mm); ld_hr = exp_hr(); ld_date = bcd(md);
        ld_mon = bcd(mmo); ld_yr = bcd(my); ld_dow = 3'(mw);
        ld_we = 7'h7f; tick = 1'b1;
        @(negedge clk);
        ld_we = '0; tick = 1'b0;
        check_time("R10");

        // R10: partial load (seconds only) with a pulse; others hold
        ms = 42; ld_sec = bcd(42); ld_we = 7'h01; tick = 1'b1;
        @(negedge clk);
        ld_we = '0; tick = 1'b0;
        check_time("R10");

        // R9: after a fresh reset, a weekday-only load arms counting
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        ld_dow = 3'd3; ld_we = 7'h40;
        @(negedge clk);
        ld_we = '0;
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        check("R9", {43'h0, sec, dow}, {43'h0, 8'h01, 3'd3});

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule